// File: doc/BRIEF.md
# Alternate Bus Master Request Arbiter

This block lets a local bus master take the shared system bus from a resident 68000-style processor and keep it. When the local master raises its request, the block pulls the active-low bus request line low. It then waits until it can be sure that the resident processor has finished its current strobe cycle. Only after that does it enable the local master's address, data and control drivers and report the bus as granted.

The block relies on two facts about the resident processor. First, it may have launched a new strobe cycle in the very clock in which the request appeared. For that reason the block lets a fixed settle interval pass after raising the request, or waits for the processor's active-low bus grant, before it trusts a high address strobe. Second, the processor only reclaims the bus when both request and acknowledge are inactive. So ownership is kept simply by holding bus request low; no acknowledge line is driven.

After reset is released, a post-reset interval must pass before any request is accepted. Throughout that interval the driver enable stays low, which keeps the local master's control outputs at their inactive high level. When the local master lets go, the driver enable drops one clock before bus request is negated. The block assumes that reset is released synchronously and that the strobe and grant inputs are synchronous to its clock.

Top module: `busreq_arbiter`

## Requirements
- R1: While `rst_n` is low, `br_n` is 1, and `drv_en` and `granted` are 0, whatever the other inputs are.
- R2: After reset is released, `br_n` stays 1 through the first BOOT_CLKS (default 4) rising edges, even with `loc_req` held at 1. With `loc_req` held, `br_n` goes to 0 just after edge BOOT_CLKS+1.
- R3: When idle and past the post-reset interval, `loc_req` = 1 sampled at a rising edge (call it E0) drives `br_n` to 0 right after E0. `br_n` never falls unless `loc_req` was 1 at the preceding edge.
- R4: With `bg_n` held at 1, ownership never starts before edge E0+SETTLE_CLKS (default 2). If `as_n` is 1 at that edge, `drv_en` and `granted` are 1 right after it.
- R5: If `bg_n` = 0 is sampled at an edge after E0 and before the settle interval has run out, the settle wait is skipped. Ownership then starts right after the first edge, at or after the one where `bg_n` was seen low, at which `as_n` = 1.
- R6: Ownership starts only after an edge at which `as_n` is sampled 1. While `as_n` stays 0, the block waits with `br_n` held at 0. In general, ownership starts at edge E0+max(a+1, min(g, SETTLE_CLKS)), where a is the number of edges after E0 with `as_n` low, and g is the offset of the first edge with `bg_n` low (SETTLE_CLKS if there is none).
- R7: While owned and `loc_req` stays 1, `br_n` stays 0 and `drv_en` and `granted` stay 1, whatever `as_n` and `bg_n` do.
- R8: When `loc_req` = 0 is sampled at an edge while owned, `drv_en` and `granted` fall right after that edge while `br_n` stays 0. `br_n` returns to 1 right after the next edge.
- R9: If `loc_req` = 0 is sampled at an edge before ownership is reached, `br_n` returns to 1 right after that edge and `drv_en` is never raised.
- R10: `drv_en` is never 1 while `br_n` is 1, and `granted` always equals `drv_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| as_n | input | 1 | Resident processor address strobe, active low |
| bg_n | input | 1 | Resident processor bus grant, active low |
| loc_req | input | 1 | Local master wants the bus |
| br_n | output | 1 | Bus request to the resident processor, active low |
| drv_en | output | 1 | Enables the local master's address, data and control drivers |
| granted | output | 1 | Local master owns the bus |

## Verification
Three events can land on the same edge while a request is pending: the settle interval running out, the early grant shortcut, and the strobe going high. The bench sweeps the number of edges with the strobe low after the request edge against the edge at which grant first falls, including "never". For every pair it predicts the ownership edge as the larger of the strobe release and the earlier of grant and settle expiry. Each case is judged edge by edge, together with the release ordering that follows. A request withdrawn on the same edge that the strobe would have allowed ownership is checked separately.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE         = 3'd0,
    ST_REQ_WAIT     = 3'd1,
    ST_WAIT_AS_HIGH = 3'd2,
    ST_OWNED        = 3'd3,
    ST_RELEASE      = 3'd4
  } arb_state_e;

endpackage

// File: rtl/busarb_boot_gate.sv
// Counts rising edges after reset release; ready once BOOT_CLKS have passed.
module busarb_boot_gate #(
  parameter int BOOT_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int CW = (BOOT_CLKS < 1) ? 1 : $clog2(BOOT_CLKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(BOOT_CLKS);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign ready  = (cnt_q == LIMIT);
  assign cnt_en = !ready;

  always_comb begin
    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/busarb_settle_timer.sv
// Counts edges spent with a request pending; done on the SETTLE_CLKS-th one.
module busarb_settle_timer #(
  parameter int SETTLE_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (SETTLE_CLKS < 2) ? 1 : $clog2(SETTLE_CLKS);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CLKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign done   = run && (cnt_q == LAST);
  assign cnt_en = !run || (cnt_q != LAST);

  always_comb begin
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/busreq_arbiter.sv
module busreq_arbiter
  import busarb_pkg::*;
#(
  parameter int BOOT_CLKS   = 4,
  parameter int SETTLE_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic as_n,
  input  logic bg_n,
  input  logic loc_req,
  output logic br_n,
  output logic drv_en,
  output logic granted
);

  arb_state_e st_q;
  arb_state_e st_d;
  logic       boot_ready;
  logic       settle_done;
  logic       settle_run;
  logic       may_take;

  busarb_boot_gate #(.BOOT_CLKS(BOOT_CLKS)) u_boot (
    .clk   (clk),
    .rst_n (rst_n),
    .ready (boot_ready)
  );

  assign settle_run = (st_q == ST_REQ_WAIT);

  busarb_settle_timer #(.SETTLE_CLKS(SETTLE_CLKS)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (settle_run),
    .done  (settle_done)
  );

  // Early grant or an expired settle window both mean the strobe can be trusted.
  assign may_take = !bg_n || settle_done;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (loc_req && boot_ready) st_d = ST_REQ_WAIT;
      end
      ST_REQ_WAIT: begin
        if (!loc_req)      st_d = ST_IDLE;
        else if (may_take) st_d = as_n ? ST_OWNED : ST_WAIT_AS_HIGH;
      end
      ST_WAIT_AS_HIGH: begin
        if (!loc_req)  st_d = ST_IDLE;
        else if (as_n) st_d = ST_OWNED;
      end
      ST_OWNED: begin
        if (!loc_req) st_d = ST_RELEASE;
      end
      ST_RELEASE: begin
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  // Moore outputs: request held in every state but idle; drivers only when owned.
  assign br_n    = (st_q == ST_IDLE);
  assign drv_en  = (st_q == ST_OWNED);
  assign granted = (st_q == ST_OWNED);

endmodule

// File: rtl/busreq_arbiter_chk.sv
module busreq_arbiter_chk #(
  parameter int BOOT_CLKS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic as_n,
  input logic loc_req,
  input logic br_n,
  input logic drv_en,
  input logic granted
);
  localparam int CW = $clog2(BOOT_CLKS + 2);
  localparam logic [CW-1:0] SAT = CW'(BOOT_CLKS + 1);

  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
    end else if (cyc_q != SAT) begin
      cyc_q <= cyc_q + CW'(1);
    end
  end

  // R1: reset forces the idle outputs
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (br_n && !drv_en && !granted)
        else $error("R1 outputs not idle in reset");
    end
  end

  // R2: no request during the post-reset interval
  a_r2_boot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q <= CW'(BOOT_CLKS)) |-> br_n);

  // R3: request only follows a local request
  a_r3_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(br_n) |-> $past(loc_req));

  // R6: ownership begins only after the strobe was seen high
  a_r6_as_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted) |-> $past(as_n));

  // R7: ownership holds while the local request stays
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (granted && loc_req) |=> (granted && !br_n));

  // R8: request is negated only once the drivers were already off
  a_r8_release_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(br_n) |-> (!drv_en && !$past(drv_en)));

  // R10: drivers never on without the request, grant flag tracks drivers
  a_r10_drv_needs_br: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (!br_n && granted));

endmodule

bind busreq_arbiter busreq_arbiter_chk #(.BOOT_CLKS(BOOT_CLKS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .as_n    (as_n),
  .loc_req (loc_req),
  .br_n    (br_n),
  .drv_en  (drv_en),
  .granted (granted)
);

// File: tb/busreq_arbiter_bench.sv
module busreq_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BOOT       = 4;
  localparam int SETTLE     = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic as_n;
  logic bg_n;
  logic loc_req;
  logic br_n;
  logic drv_en;
  logic granted;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  busreq_arbiter #(.BOOT_CLKS(BOOT), .SETTLE_CLKS(SETTLE)) u_busreq_arbiter (
    .clk     (clk),
    .rst_n   (rst_n),
    .as_n    (as_n),
    .bg_n    (bg_n),
    .loc_req (loc_req),
    .br_n    (br_n),
    .drv_en  (drv_en),
    .granted (granted)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // Advance one rising edge and settle a little after it.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int own_edge(input int a, input int g);
    int gate;
    gate = (g > 0 && g < SETTLE) ? g : SETTLE;
    return (a + 1 > gate) ? a + 1 : gate;
  endfunction

  task automatic outs(input string tag, input logic e_br, input logic e_own);
    chk(tag, "br_n", br_n, e_br);
    chk(tag, "drv_en", drv_en, e_own);
    chk("R10", "granted", granted, e_own);
  endtask

  initial begin
    rst_n = 1'b0; loc_req = 1'b1; as_n = 1'b0; bg_n = 1'b0;
    #2;
    repeat (3) begin
      tick();
      outs("R1", 1'b1, 1'b0);
    end
    rst_n = 1'b1;
    as_n = 1'b1; bg_n = 1'b1;
    // post-reset interval with request held; own at BOOT+1+SETTLE
    for (int k = 1; k <= BOOT + SETTLE + 3; k++) begin
      tick();
      if (k <= BOOT + SETTLE) chk("R2", "br_n", br_n, (k <= BOOT) ? 1'b1 : 1'b0);
      chk("R4", "granted", granted, (k >= BOOT + 1 + SETTLE) ? 1'b1 : 1'b0);
    end
    loc_req = 1'b0;
    tick(); outs("R8", 1'b0, 1'b0);
    tick(); outs("R8", 1'b1, 1'b0);
    tick(); outs("R3", 1'b1, 1'b0);

    // sweep: a = strobe-low edges after request, g = first grant-low offset (0 = none)
    for (int a = 0; a <= 4; a++) begin
      for (int g = 0; g <= 4; g++) begin
        int n;
        string tag;
        n = own_edge(a, g);
        if (g > 0 && g < SETTLE && a + 1 < SETTLE) tag = "R5";
        else if (a + 1 > SETTLE) tag = "R6";
        else tag = "R4";
        for (int k = 0; k <= 8; k++) begin
          loc_req = 1'b1;
          if (k > n) as_n = k[0];
          else as_n = (k <= a) ? 1'b0 : 1'b1;
          if (k > n) bg_n = ~k[0];
          else bg_n = (g > 0 && k >= g) ? 1'b0 : 1'b1;
          tick();
          if (k > n) outs("R7", 1'b0, 1'b1);
          else outs((k == 0) ? "R3" : tag, 1'b0, (k >= 1 && k >= n) ? 1'b1 : 1'b0);
        end
        loc_req = 1'b0; as_n = 1'b1; bg_n = 1'b1;
        tick(); outs("R8", 1'b0, 1'b0);
        tick(); outs("R8", 1'b1, 1'b0);
      end
    end

    // withdrawal from the first wait state while the strobe is busy
    loc_req = 1'b1; as_n = 1'b0; bg_n = 1'b1;
    tick(); outs("R9", 1'b0, 1'b0);
    loc_req = 1'b0;
    tick(); outs("R9", 1'b1, 1'b0);
    // withdrawal from the strobe wait on the edge the strobe goes high
    loc_req = 1'b1; as_n = 1'b0; bg_n = 1'b0;
    tick(); outs("R9", 1'b0, 1'b0);
    tick(); outs("R9", 1'b0, 1'b0);
    loc_req = 1'b0; as_n = 1'b1;
    tick(); outs("R9", 1'b1, 1'b0);
    tick(); outs("R9", 1'b1, 1'b0);

    // reset in the middle of ownership
    loc_req = 1'b1; bg_n = 1'b1;
    repeat (4) tick();
    chk("R4", "granted", granted, 1'b1);
    rst_n = 1'b0;
    #1;
    outs("R1", 1'b1, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule